// File: doc/BRIEF.md
# Page Column Mapper with Marker Skip

This block turns a stream of logical bytes into physical column addresses within one flash page. The stream holds, sector after sector, the user data of a sector followed at once by that sector's check bytes. The page has a main area followed by a spare area. The stream is laid down linearly across the page. When the column reaches the first spare byte, the mapper inserts a fixed gap over the factory bad-block marker so that no data or check byte is ever placed there. It then resumes the stream in the spare area. Once the last check byte has been placed, the remaining spare bytes are walked as a flags region, and a one-cycle completion pulse follows.

The surrounding engine pulses `start_i` to begin a page. It then offers one logical byte per cycle on `byte_vld_i` and uses `take_o` to learn that the byte was placed at `col_o`. For every position, `region_o` and `sector_o` tell the engine whether the position is data, check bytes, marker gap or flags, and which sector it belongs to. The mapper does not compute check bytes and does not sequence flash commands.

Top module: `bbm_col_mapper`

## Requirements
- R1: After reset `active_o`=0, `done_o`=0, `col_o`=0 and `lidx_o`=0. While idle, `byte_vld_i` has no effect: `active_o` stays 0 and `col_o` stays 0.
- R2: In the cycle after a `start_i` pulse, `active_o`=1, `col_o`=0, `lidx_o`=0, `region_o`=0 (data) and `sector_o`=0. A `start_i` during a transfer restarts it from column 0 and logical index 0.
- R3: In a data or check region, the column and the logical index advance by one only in a cycle with `byte_vld_i`=1. With `byte_vld_i`=0 both hold.
- R4: For logical index L, the sector is L/526 and the region tag is 0 (data) when L mod 526 < 512 and 1 (check) otherwise. Sectors 0–3 are 526 bytes each.
- R5: In data and check regions, the column equals L for L < 2048 and L+2 for L ≥ 2048.
- R6: Columns 2048 and 2049 carry region tag 2 (marker gap) and sector 3, with `stall_o`=1 and `take_o`=0. They take exactly two cycles whatever `byte_vld_i` does, and `lidx_o` holds at 2048.
- R7: Columns 2106–2111 carry region tag 3 (flags) and sector 3, with `stall_o`=1. They advance one per cycle without consuming bytes, and `lidx_o` holds at 2104.
- R8: `done_o` is high for exactly one cycle, the cycle after column 2111 is presented. In that cycle `active_o` is 0 and `col_o` is back at 0.
- R9: `take_o` = `active_o` AND `byte_vld_i` AND (region tag is 0 or 1). `stall_o` = `active_o` AND (region tag is 2 or 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin (or restart) a page transfer |
| byte_vld_i | input | 1 | A logical byte is offered this cycle |
| active_o | output | 1 | A transfer is in progress |
| take_o | output | 1 | The offered byte is placed at `col_o` this cycle |
| stall_o | output | 1 | Gap or flags position, no byte consumed |
| col_o | output | 12 | Physical column of the current position |
| region_o | output | 2 | 0 data, 1 check bytes, 2 marker gap, 3 flags |
| sector_o | output | 2 | Sector index of the current position |
| lidx_o | output | 12 | Logical byte index (data and check bytes only) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default geometry: a 2048-byte main area, a 64-byte spare area, four sectors of 512 data and 14 check bytes, and a 2-byte marker. With these values the marker falls inside the data of the last sector, so a single page run passes through the split sector, the gap, the check bytes in the spare area and the flags tail. A table of every region edge is checked in three runs: one with bytes offered back to back, one with bytes withheld every third cycle (which shows that the gap and flags advance with no bytes offered), and one restarted mid-page.

// File: rtl/bbm_map_pkg.sv
package bbm_map_pkg;

  typedef enum logic [1:0] {
    RG_DATA  = 2'd0,
    RG_ECC   = 2'd1,
    RG_SKIP  = 2'd2,
    RG_FLAGS = 2'd3
  } region_e;

  // sector of a logical index, clamped to the last sector for the tail
  function automatic int sect_of(input int lidx, input int sect_bytes, input int nsect);
    int s;
    s = lidx / sect_bytes;
    if (s > nsect - 1) s = nsect - 1;
    return s;
  endfunction

  // physical column that a logical index lands on
  function automatic int col_of(input int lidx, input int main_bytes, input int mark_bytes);
    return (lidx >= main_bytes) ? lidx + mark_bytes : lidx;
  endfunction

  // region tag of a position given both the column and the logical index
  function automatic region_e region_of(input int col, input int lidx, input int main_bytes,
                                        input int mark_bytes, input int data_bytes,
                                        input int sect_bytes, input int total);
    if (col >= main_bytes && col < main_bytes + mark_bytes) return RG_SKIP;
    if (lidx >= total) return RG_FLAGS;
    if ((lidx % sect_bytes) < data_bytes) return RG_DATA;
    return RG_ECC;
  endfunction

endpackage

// File: rtl/bbm_region_dec.sv
module bbm_region_dec
  import bbm_map_pkg::*;
#(
  parameter int MAIN_BYTES = 2048,
  parameter int MARK_BYTES = 2,
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 14,
  parameter int SECTORS    = 4,
  parameter int COL_W      = 12,
  parameter int SEC_W      = 2
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] lidx_i,
  output region_e          region_o,
  output logic [SEC_W-1:0] sector_o
);
  localparam int SECT_BYTES = DATA_BYTES + ECC_BYTES;
  localparam int TOTAL      = SECTORS * SECT_BYTES;

  always_comb begin
    region_o = region_of(int'(col_i), int'(lidx_i), MAIN_BYTES, MARK_BYTES,
                         DATA_BYTES, SECT_BYTES, TOTAL);
    sector_o = SEC_W'(sect_of(int'(lidx_i), SECT_BYTES, SECTORS));
  end

endmodule

// File: rtl/bbm_cursor.sv
module bbm_cursor
  import bbm_map_pkg::*;
#(
  parameter int MAIN_BYTES = 2048,
  parameter int PAGE_BYTES = 2112,
  parameter int MARK_BYTES = 2,
  parameter int COL_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_vld_i,
  input  region_e          region_i,
  output logic             active_o,
  output logic             take_o,
  output logic             stall_o,
  output logic             done_o,
  output logic [COL_W-1:0] col_o,
  output logic [COL_W-1:0] lidx_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  logic             active_q, done_q;
  logic [COL_W-1:0] col_q, lidx_q;

  // named events for the assertions
  logic consume;   // position takes a stream byte
  logic advance;   // position moves on this cycle
  logic at_last;   // final column of the page

  assign consume = (region_i == RG_DATA) || (region_i == RG_ECC);
  assign advance = active_q && (consume ? byte_vld_i : 1'b1);
  assign at_last = (col_q == LAST_COL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      col_q    <= '0;
      lidx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        col_q    <= '0;
        lidx_q   <= '0;
      end else if (advance) begin
        if (at_last) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          col_q    <= '0;
          lidx_q   <= '0;
        end else begin
          col_q <= col_q + 1'b1;
          if (consume) lidx_q <= lidx_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
  assign col_o    = col_q;
  assign lidx_o   = lidx_q;
  assign take_o   = active_q && byte_vld_i && consume;
  assign stall_o  = active_q && !consume;

  // R6: the marker gap never consumes a stream byte
  a_r6_skip_holds_lidx: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && region_i == RG_SKIP && !start_i) |=> $stable(lidx_q));

  // R5: column and logical index stay in step outside the gap and tail
  a_r5_col_tracks_lidx: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && consume) |->
      (int'(col_q) == int'(lidx_q) + ((int'(lidx_q) >= MAIN_BYTES) ? MARK_BYTES : 0)));

  // R3: no offered byte, no movement in a data or check position
  a_r3_hold_without_vld: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && consume && !byte_vld_i && !start_i) |=> $stable(col_q));

  // R8: completion follows the last column and lasts one cycle
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && at_last && !start_i) |=> (done_q && !active_q));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R1: idle state sits at column zero
  a_r1_idle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start_i) |=> (col_q == '0));

endmodule

// File: rtl/bbm_col_mapper.sv
module bbm_col_mapper
  import bbm_map_pkg::*;
#(
  parameter int MAIN_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int MARK_BYTES  = 2,
  parameter int DATA_BYTES  = 512,
  parameter int ECC_BYTES   = 14,
  parameter int SECTORS     = 4,
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
  localparam int COL_W      = $clog2(PAGE_BYTES),
  localparam int SEC_W      = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_vld_i,
  output logic             active_o,
  output logic             take_o,
  output logic             stall_o,
  output logic [COL_W-1:0] col_o,
  output logic [1:0]       region_o,
  output logic [SEC_W-1:0] sector_o,
  output logic [COL_W-1:0] lidx_o,
  output logic             done_o
);
  region_e          region_w;
  logic [COL_W-1:0] col_w, lidx_w;

  bbm_cursor #(
    .MAIN_BYTES (MAIN_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .MARK_BYTES (MARK_BYTES),
    .COL_W      (COL_W)
  ) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .region_i   (region_w),
    .active_o   (active_o),
    .take_o     (take_o),
    .stall_o    (stall_o),
    .done_o     (done_o),
    .col_o      (col_w),
    .lidx_o     (lidx_w)
  );

  bbm_region_dec #(
    .MAIN_BYTES (MAIN_BYTES),
    .MARK_BYTES (MARK_BYTES),
    .DATA_BYTES (DATA_BYTES),
    .ECC_BYTES  (ECC_BYTES),
    .SECTORS    (SECTORS),
    .COL_W      (COL_W),
    .SEC_W      (SEC_W)
  ) u_dec (
    .col_i    (col_w),
    .lidx_i   (lidx_w),
    .region_o (region_w),
    .sector_o (sector_o)
  );

  assign col_o    = col_w;
  assign lidx_o   = lidx_w;
  assign region_o = region_w;

endmodule

// File: tb/bbm_col_mapper_bench.sv
`timescale 1ns/1ps
module bbm_col_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic        active_o, take_o, stall_o, done_o;
  logic [11:0] col_o, lidx_o;
  logic [1:0]  region_o, sector_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bbm_col_mapper u_bbm_col_mapper (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .active_o(active_o), .take_o(take_o), .stall_o(stall_o), .col_o(col_o),
    .region_o(region_o), .sector_o(sector_o), .lidx_o(lidx_o), .done_o(done_o)
  );

  // edge table: {col[27:16], region[15:14], sector[13:12], lidx[11:0]}
  localparam logic [27:0] EDGES [18] = '{
    {12'd0,    2'd0, 2'd0, 12'd0},
    {12'd511,  2'd0, 2'd0, 12'd511},
    {12'd512,  2'd1, 2'd0, 12'd512},
    {12'd525,  2'd1, 2'd0, 12'd525},
    {12'd526,  2'd0, 2'd1, 12'd526},
    {12'd1051, 2'd1, 2'd1, 12'd1051},
    {12'd1052, 2'd0, 2'd2, 12'd1052},
    {12'd1577, 2'd1, 2'd2, 12'd1577},
    {12'd1578, 2'd0, 2'd3, 12'd1578},
    {12'd2047, 2'd0, 2'd3, 12'd2047},
    {12'd2048, 2'd2, 2'd3, 12'd2048},
    {12'd2049, 2'd2, 2'd3, 12'd2048},
    {12'd2050, 2'd0, 2'd3, 12'd2048},
    {12'd2091, 2'd0, 2'd3, 12'd2089},
    {12'd2092, 2'd1, 2'd3, 12'd2090},
    {12'd2105, 2'd1, 2'd3, 12'd2103},
    {12'd2106, 2'd3, 2'd3, 12'd2104},
    {12'd2111, 2'd3, 2'd3, 12'd2104}
  };

  function automatic bit takes_byte(input int c);
    return (c < 2048) || (c >= 2050 && c < 2106);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // mode 0: back to back, 1: every third byte withheld, 2: restart at cycle 300
  task automatic run_page(input int mode);
    int ec = 0;
    int el = 0;
    bit vld;
    bit seen_last = 0;
    bit restart;
    @(posedge clk); #1 start_i = 1'b1; byte_vld_i = 1'b0;
    @(posedge clk); #1 start_i = 1'b0;
    chk("R2 active after start", int'(active_o), 1);
    chk("R2 region after start", int'(region_o), 0);
    chk("R2 sector after start", int'(sector_o), 0);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      vld = (mode == 1) ? (cyc % 3 != 0) : 1'b1;
      restart = (mode == 2) && (cyc == 300);
      byte_vld_i = vld;
      start_i = restart;
      @(negedge clk);
      if (!active_o) begin
        chk("R8 transfer ran to last column", int'(seen_last), 1);
        chk("R8 done pulse", int'(done_o), 1);
        chk("R8 column back at zero", int'(col_o), 0);
        break;
      end
      chk("R5 column", int'(col_o), ec);
      chk("R3 logical index", int'(lidx_o), el);
      chk("R9 take", int'(take_o), int'(vld && takes_byte(ec)));
      chk("R6 R7 stall", int'(stall_o), int'(!takes_byte(ec)));
      for (int i = 0; i < 18; i++) begin
        if (int'(EDGES[i][27:16]) == ec) begin
          chk("R4 R6 R7 region", int'(region_o), int'(EDGES[i][15:14]));
          chk("R4 sector", int'(sector_o), int'(EDGES[i][13:12]));
          chk("R5 edge logical index", int'(lidx_o), int'(EDGES[i][11:0]));
        end
      end
      if (ec == 2111) seen_last = 1;
      if (restart) begin
        ec = 0; el = 0; seen_last = 0;
      end else if (takes_byte(ec)) begin
        if (vld) begin ec++; el++; end
      end else begin
        ec++;
      end
      @(posedge clk); #1;
    end
    start_i = 1'b0;
    byte_vld_i = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R8 done lasts one cycle", int'(done_o), 0);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 active in reset", int'(active_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    chk("R1 column in reset", int'(col_o), 0);
    chk("R1 index in reset", int'(lidx_o), 0);
    rst_n = 1'b1;
    // R1 idle ignores offered bytes
    byte_vld_i = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 idle stays inactive", int'(active_o), 0);
    chk("R1 idle column", int'(col_o), 0);
    chk("R1 idle take", int'(take_o), 0);
    byte_vld_i = 1'b0;

    run_page(0);   // R4 R5 R6 R7 R8 back to back
    run_page(1);   // R3 R6 withheld bytes
    run_page(2);   // R2 restart mid page

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule